// File: doc/BRIEF.md
# Timer-Shared GPIO Port Controller

This block controls a general-purpose I/O port whose pins can be claimed, a group of channels at a time, by external timer modules. Software sees three byte registers: a port latch it can write and read back, a direction mask, and a read-only view of the synchronized pin levels. Each pin is driven either from the latch under the direction mask or from an output-compare channel of the timer that covers that pin.

Timers own pins in fixed groups. Timer 0 covers the lowest group of pins and timer 1 the next group. Channel n of a timer maps to pin n of its group. A timer takes a pin only while that timer is enabled and that channel is set to output compare. While it owns the pin, the timer level is driven and the output enable is forced on, whatever the direction bit says. In every other case the pin is under GPIO control.

Pin levels pass through a two-stage synchronizer before software can read them. Reads of the latch register are per bit: an output bit returns the stored value and an input bit returns the synchronized pin.

Top module: `tshare_gpio_port`

## Requirements
- R1: While reset is high, every output enable is low. After a reset the port latch and the direction mask (offset 2) both hold zero.
- R2: A write to offset 0 stores the write data in the port latch. Reading offset 0 returns the latch bit for every bit whose direction bit is 1.
- R3: Reading offset 0 returns the synchronized pin level for every bit whose direction bit is 0. The choice is made bit by bit.
- R4: Reading offset 1 always returns the synchronized pin levels, for any direction setting. A write to offset 1 leaves the latch and the direction mask unchanged.
- R5: Offset 2 holds the direction mask and can be written and read back. Offset 3 reads as zero.
- R6: On a pin that no timer owns, the output level equals the latch bit and the output enable equals the direction bit.
- R7: When timer 0 is enabled and its channel n (n = 0 to 3) is set to output compare, pin n drives that channel's compare level with its output enable at 1.
- R8: When timer 1 is enabled and its channel n is set to output compare, pin 4+n drives that channel's compare level with its output enable at 1.
- R9: A channel set to output compare on a disabled timer, or a channel not set to output compare on an enabled timer, leaves its pin under GPIO control.
- R10: A pin change shows in register reads after exactly two rising clock edges. After a single edge the read still returns the old level.
- R11: The pin synchronizer is not cleared by reset. Offset 1 returns the pin levels during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Pin levels, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register byte offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from the offset |
| tmr_en | input | 2 | Enable of each timer |
| tmr_oc_sel | input | 8 | Output-compare selection per channel, timer 0 in the low group |
| tmr_oc_val | input | 8 | Output-compare level per channel |
| pin_out | output | 8 | Level driven onto each pin |
| pin_oe | output | 8 | Output enable of each pin |

## Verification
The bench uses the default parameters: two timers of four channels each, which gives an 8-bit port. With this size both timer groups can be exercised, including pins 0, 3, 4 and 7 at the group edges. The bench also checks the override while a timer is disabled, and a direction mask that mixes inputs and outputs so that the per-bit read selection can be seen.

// File: rtl/tshare_gpio_pkg.sv
package tshare_gpio_pkg;

    localparam int unsigned OFS_W = 2;

    typedef enum logic [OFS_W-1:0] {
        OFS_LATCH  = 2'd0,
        OFS_LEVELS = 2'd1,
        OFS_DIR    = 2'd2,
        OFS_VOID   = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic level;
        logic enable;
    } pin_drive_t;

    function automatic pin_drive_t pick_drive(
        input logic owned,
        input logic tmr_level,
        input logic latch_bit,
        input logic dir_bit
    );
        pin_drive_t d;
        if (owned) begin
            d.level  = tmr_level;
            d.enable = 1'b1;
        end else begin
            d.level  = latch_bit;
            d.enable = dir_bit;
        end
        return d;
    endfunction

endpackage

// File: rtl/tshare_gpio_sync.sv
module tshare_gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/tshare_gpio_regs.sv
module tshare_gpio_regs
    import tshare_gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [OFS_W-1:0] addr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q
);
    reg_ofs_e ofs;
    assign ofs = reg_ofs_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (we) begin
            unique case (ofs)
                OFS_LATCH: latch_q <= wdata;
                OFS_DIR:   dir_q   <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_LATCH:  rdata = (dir_q & latch_q) | (~dir_q & pin_sync);
            OFS_LEVELS: rdata = pin_sync;
            OFS_DIR:    rdata = dir_q;
            default:    rdata = '0;
        endcase
    end

    // R1: both registers come out of reset cleared
    a_r1_regs_cleared: assert property (@(posedge clk)
        $fell(rst) |-> (latch_q == '0 && dir_q == '0));

    // R2: a write to the latch offset lands in the latch
    a_r2_latch_write: assert property (@(posedge clk) disable iff (rst)
        (we && addr == OFS_LATCH) |=> latch_q == $past(wdata));

    // R5: a write to the direction offset lands in the mask
    a_r5_dir_write: assert property (@(posedge clk) disable iff (rst)
        (we && addr == OFS_DIR) |=> dir_q == $past(wdata));

    // R4: writes to the level view leave both registers unchanged
    a_r4_levels_readonly: assert property (@(posedge clk) disable iff (rst)
        (we && addr == OFS_LEVELS) |=> (latch_q == $past(latch_q) && dir_q == $past(dir_q)));
endmodule

// File: rtl/tshare_gpio_pinmux.sv
module tshare_gpio_pinmux
    import tshare_gpio_pkg::*;
#(
    parameter int unsigned TIMERS   = 2,
    parameter int unsigned CHANNELS = 4,
    localparam int unsigned PINS    = TIMERS * CHANNELS
) (
    input  logic              rst,
    input  logic [TIMERS-1:0] tmr_en,
    input  logic [PINS-1:0]   oc_sel,
    input  logic [PINS-1:0]   oc_val,
    input  logic [PINS-1:0]   latch_q,
    input  logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        localparam int unsigned OWNER = p / CHANNELS;
        logic       owned;
        pin_drive_t drv;

        assign owned      = tmr_en[OWNER] & oc_sel[p];
        assign drv        = pick_drive(owned, oc_val[p], latch_q[p], dir_q[p]);
        assign pin_out[p] = drv.level;
        assign pin_oe[p]  = drv.enable & ~rst;
    end
endmodule

// File: rtl/tshare_gpio_port.sv
module tshare_gpio_port
    import tshare_gpio_pkg::*;
#(
    parameter int unsigned TIMERS    = 2,
    parameter int unsigned CHANNELS  = 4,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [TIMERS*CHANNELS-1:0]   pin_in,
    input  logic                         bus_we,
    input  logic [OFS_W-1:0]             bus_addr,
    input  logic [TIMERS*CHANNELS-1:0]   bus_wdata,
    output logic [TIMERS*CHANNELS-1:0]   bus_rdata,
    input  logic [TIMERS-1:0]            tmr_en,
    input  logic [TIMERS*CHANNELS-1:0]   tmr_oc_sel,
    input  logic [TIMERS*CHANNELS-1:0]   tmr_oc_val,
    output logic [TIMERS*CHANNELS-1:0]   pin_out,
    output logic [TIMERS*CHANNELS-1:0]   pin_oe
);
    localparam int unsigned PINS = TIMERS * CHANNELS;

    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] latch_q;
    logic [PINS-1:0] dir_q;

    tshare_gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    tshare_gpio_regs #(.WIDTH(PINS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata),
        .latch_q  (latch_q),
        .dir_q    (dir_q)
    );

    tshare_gpio_pinmux #(.TIMERS(TIMERS), .CHANNELS(CHANNELS)) u_mux (
        .rst     (rst),
        .tmr_en  (tmr_en),
        .oc_sel  (tmr_oc_sel),
        .oc_val  (tmr_oc_val),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // R1: no pin is driven while reset is held
    always_comb begin
        if (rst) begin
            a_r1_oe_quiet: assert (pin_oe == '0);
        end
    end

    for (genvar p = 0; p < PINS; p++) begin : g_chk
        localparam int unsigned OWNER = p / CHANNELS;

        // R7 / R8: an enabled output-compare channel drives its pin
        a_r7_r8_timer_drive: assert property (@(posedge clk) disable iff (rst)
            (tmr_en[OWNER] && tmr_oc_sel[p]) |-> (pin_oe[p] && pin_out[p] == tmr_oc_val[p]));

        // R6 / R9: pins that no timer owns follow the latch and direction mask
        a_r6_r9_gpio_drive: assert property (@(posedge clk) disable iff (rst)
            !(tmr_en[OWNER] && tmr_oc_sel[p]) |-> (pin_oe[p] == dir_q[p] && pin_out[p] == latch_q[p]));
    end
endmodule

// File: tb/tshare_gpio_port_tb_top.sv
`timescale 1ns/1ps
module tshare_gpio_port_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] pin_in;
    logic       bus_we;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [1:0] tmr_en;
    logic [7:0] tmr_oc_sel;
    logic [7:0] tmr_oc_val;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    always #10 clk = ~clk;

    tshare_gpio_port dut_i (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_en(tmr_en), .tmr_oc_sel(tmr_oc_sel), .tmr_oc_val(tmr_oc_val),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    typedef enum int {K_RDATA, K_OUT, K_OE} kind_e;
    typedef struct {
        kind_e      kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    // monitor: compares queued expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_RDATA: act = bus_rdata;
                    K_OUT:   act = pin_out;
                    default: act = pin_oe;
                endcase
                compared++;
                if (act !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic expect_item(kind_e k, logic [7:0] e, string tag);
        item_t it;
        it.kind = k;
        it.exp  = e;
        it.tag  = tag;
        q.push_back(it);
        step(1);
    endtask

    task automatic expect_rd(logic [1:0] a, logic [7:0] e, string tag);
        bus_addr = a;
        expect_item(K_RDATA, e, tag);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        step(1);
        bus_we    = 1'b0;
    endtask

    initial begin
        rst = 1'b1; pin_in = 8'hA5; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
        tmr_en = 2'b00; tmr_oc_sel = 8'h00; tmr_oc_val = 8'h00;
        step(3);
        expect_item(K_OE, 8'h00, "R1 oe low during reset");
        expect_rd(2'd1, 8'hA5, "R11 levels visible during reset");
        rst = 1'b0;
        expect_rd(2'd2, 8'h00, "R1 direction cleared");
        expect_item(K_OE, 8'h00, "R1 oe after reset");
        expect_item(K_OUT, 8'h00, "R6 latch drives zero");
        wr(2'd2, 8'hFF);
        expect_rd(2'd0, 8'h00, "R1 latch cleared");
        wr(2'd0, 8'h3C);
        expect_rd(2'd0, 8'h3C, "R2 latch readback");
        expect_item(K_OUT, 8'h3C, "R6 gpio level");
        expect_item(K_OE, 8'hFF, "R6 gpio enable");
        wr(2'd2, 8'h0F);
        expect_rd(2'd0, 8'hAC, "R3 mixed direction read");
        expect_rd(2'd2, 8'h0F, "R5 direction readback");
        // R10: one edge is not enough, the second edge makes it visible
        bus_addr = 2'd1;
        pin_in   = 8'h5A;
        expect_rd(2'd1, 8'hA5, "R10 old level after one edge");
        expect_rd(2'd1, 8'h5A, "R10 new level after two edges");
        expect_rd(2'd0, 8'h5C, "R3 mixed read new pins");
        wr(2'd1, 8'hFF);
        expect_rd(2'd1, 8'h5A, "R4 levels unaffected by write");
        expect_rd(2'd0, 8'h5C, "R4 latch unaffected by levels write");
        expect_rd(2'd2, 8'h0F, "R4 direction unaffected by levels write");
        expect_rd(2'd3, 8'h00, "R5 void offset reads zero");
        wr(2'd2, 8'h00);
        expect_item(K_OE, 8'h00, "R6 all inputs");
        tmr_en = 2'b01; tmr_oc_sel = 8'h05; tmr_oc_val = 8'h01;
        expect_item(K_OUT, 8'h39, "R7 timer0 levels");
        expect_item(K_OE, 8'h05, "R7 timer0 enables override direction");
        tmr_en = 2'b10; tmr_oc_sel = 8'h55; tmr_oc_val = 8'h41;
        expect_item(K_OUT, 8'h6C, "R8 timer1 levels, R9 timer0 disabled");
        expect_item(K_OE, 8'h50, "R8 timer1 enables, R9 timer0 disabled");
        tmr_en = 2'b11; tmr_oc_sel = 8'h00; tmr_oc_val = 8'hFF;
        expect_item(K_OUT, 8'h3C, "R9 no channel selected");
        expect_item(K_OE, 8'h00, "R9 no channel selected");
        tmr_oc_sel = 8'h88; tmr_oc_val = 8'h80;
        expect_item(K_OUT, 8'hB4, "R7 R8 edge pins 3 and 7");
        expect_item(K_OE, 8'h88, "R7 R8 edge pins 3 and 7");
        rst = 1'b1;
        step(1);
        expect_item(K_OE, 8'h00, "R1 oe low in reset with timers on");
        expect_rd(2'd1, 8'h5A, "R11 levels kept through reset");
        rst = 1'b0;
        tmr_en = 2'b00;
        expect_rd(2'd1, 8'h5A, "R11 levels right after reset");
        expect_rd(2'd0, 8'h5A, "R1 R3 latch cleared, inputs read pins");
        step(2);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule